// File: doc/BRIEF.md
# Line-Rate Loop Lock Monitor

This block judges the state of a horizontal phase-locked loop from the error pulses of its phase-frequency comparator. A leaky digital integrator stands in for an analogue RC filter. It is sampled once per line, on a line strobe. Each line whose error pulses are all short pushes the level up toward full scale. A line with a long error pulse bleeds a fraction of the level away. A long absence of line strobes lets the level decay toward zero.

From the integrated level the block derives three outputs. The first is a lock flag that goes low when the loop is not locked. The second is a two-bit grade of the loop condition: no sync, wrong frequency, right frequency but wrong phase, or locked. The third is a blanking request. It covers the whole unlocked interval and then a programmable number of further lines after lock returns, so the picture stays dark while the loop settles after a frequency change.

Top module: `pll_lock_monitor`

## Requirements
- R1: After reset the level is 0, `status_o` is 2'b00, `lock_o` is 0 and `blank_req_o` is 1.
- R2: The error signal is `err_up | err_dn`. An unbroken run of it lasting at most 8 cycles is narrow, and a run of 9 or more cycles is wide. A line is wide when any wide run occurs between its strobe and the previous strobe. Otherwise, including a line with no error at all, it is narrow.
- R3: At the strobe of a narrow line, the level rises by 16 and saturates at 1023.
- R4: At the strobe of a wide line, the level falls by d. Here d = level>>3 when the level is at least 8, d = 1 when the level is 1 to 7, and d = 0 when the level is 0.
- R5: Every time 1024 consecutive cycles pass without a line strobe, the level falls by the same d as in R4.
- R6: `lock_o` is 1 exactly when the level is at least 829 (about 81% of full scale).
- R7: `status_o` encodes the level: 2'b00 below 64 (no sync), 2'b01 from 64 to 511 (frequency mismatch), 2'b10 from 512 to 959 (frequency right, phase wrong), 2'b11 from 960 up (locked).
- R8: `blank_req_o` is 1 while `lock_o` is 0. It stays 1 for `blank_lines` further strobes after `lock_o` rises, and it drops right after the last of them. With `blank_lines` = 0 it falls together with `lock_o`.
- R9: The level changes only at a strobe edge or a timeout edge, and all outputs reflect it from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_up | input | 1 | Comparator "advance" error pulse |
| err_dn | input | 1 | Comparator "retard" error pulse |
| line_stb | input | 1 | One-cycle strobe per horizontal line |
| blank_lines | input | BL_W | Lines of extra blanking after lock returns |
| lock_o | output | 1 | 1 when locked, 0 when unlocked |
| status_o | output | 2 | Graded loop condition (R7) |
| blank_req_o | output | 1 | Blanking request |

## Verification
Every result is due in the cycle after the edge that caused it. A line's effect shows one clock after its strobe edge, and a decay shows one clock after the 1024th idle edge. The bench drives inputs on falling edges and samples on the falling edge right after each strobe. It runs timeouts half a period past the decay edge, so each sample falls in a window where the expected value is already settled. Pulse widths are swept from 0 to 14 cycles from a known saturated level. Full climbs and decays are tracked line by line against an arithmetic model of the level.

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor #(
  parameter int LVL_W      = 10,
  parameter int NARROW_MAX = 8,
  parameter int STEP       = 16,
  parameter int SHIFT      = 3,
  parameter int IDLE_LIM   = 1024,
  parameter int LOCK_TH    = 829,
  parameter int ZERO_TH    = 64,
  parameter int HALF_TH    = 512,
  parameter int FULL_TH    = 960,
  parameter int BL_W       = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            err_up,
  input  logic            err_dn,
  input  logic            line_stb,
  input  logic [BL_W-1:0] blank_lines,
  output logic            lock_o,
  output logic [1:0]      status_o,
  output logic            blank_req_o
);
  localparam int CW = $clog2(NARROW_MAX + 2);
  localparam int IW = $clog2(IDLE_LIM);
  localparam logic [LVL_W-1:0] LVL_MAX = '1;

  logic             err, long_now, wide_now, wide_seen, timeout;
  logic [CW-1:0]    wcnt;
  logic [IW-1:0]    idle;
  logic [LVL_W-1:0] level, dec, inc;
  logic [LVL_W:0]   sum;
  logic [BL_W-1:0]  hold;

  assign err      = err_up | err_dn;
  assign long_now = err && (wcnt >= CW'(NARROW_MAX));
  assign wide_now = wide_seen | long_now;
  assign timeout  = !line_stb && (idle == IW'(IDLE_LIM - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !err) wcnt <= '0;
    else if (!long_now) wcnt <= wcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || line_stb) wide_seen <= 1'b0;
    else if (long_now)      wide_seen <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || line_stb || timeout) idle <= '0;
    else                               idle <= idle + 1'b1;
  end

  assign dec = (level >= LVL_W'(1 << SHIFT)) ? (level >> SHIFT) : LVL_W'(level != '0);
  assign sum = {1'b0, level} + (LVL_W+1)'(STEP);
  assign inc = sum[LVL_W] ? LVL_MAX : sum[LVL_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)        level <= '0;
    else if (line_stb) level <= wide_now ? level - dec : inc;
    else if (timeout)  level <= level - dec;
  end

  assign lock_o   = level >= LVL_W'(LOCK_TH);
  assign status_o = (level < LVL_W'(ZERO_TH)) ? 2'b00 :
                    (level < LVL_W'(HALF_TH)) ? 2'b01 :
                    (level < LVL_W'(FULL_TH)) ? 2'b10 : 2'b11;

  always_ff @(posedge clk) begin
    if (!rst_n)                       hold <= '0;
    else if (!lock_o)                 hold <= blank_lines;
    else if (line_stb && hold != '0)  hold <= hold - 1'b1;
  end

  assign blank_req_o = !lock_o || (hold != '0);

  // R9
  level_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_stb && !timeout) |=> $stable(level));
  // R3
  narrow_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_stb && !wide_now && level == LVL_MAX) |=> level == LVL_MAX);
  // R7
  graded_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == 2'b11) |-> lock_o);
  // R8
  blank_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_o |-> blank_req_o);
  // R8
  blank_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blank_req_o) |-> lock_o);
  // R4
  wide_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_stb && wide_now && level != '0) |=> level < $past(level));
endmodule

// File: tb/pll_lock_monitor_tb_top.sv
module pll_lock_monitor_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, err_up = 1'b0, err_dn = 1'b0, line_stb = 1'b0;
  logic [7:0] blank_lines = 8'd3;
  logic lock_o, blank_req_o;
  logic [1:0] status_o;

  int n_chk = 0, n_fail = 0, mlvl = 0, mhold = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  pll_lock_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .err_up(err_up), .err_dn(err_dn),
    .line_stb(line_stb), .blank_lines(blank_lines),
    .lock_o(lock_o), .status_o(status_o), .blank_req_o(blank_req_o));

  function automatic int mdec(int l);
    if (l >= 8) return l >> 3;
    return (l != 0) ? 1 : 0;
  endfunction
  function automatic int mstat(int l);
    if (l < 64)  return 0;
    if (l < 512) return 1;
    if (l < 960) return 2;
    return 3;
  endfunction
  function automatic bit mlock(int l);
    return l >= 829;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (level model %0d)", tag, act, exp, mlvl);
    end
  endtask

  task automatic chk_all(string tag);
    chk({tag, " R6 lock"}, int'(lock_o), int'(mlock(mlvl)));
    chk({tag, " R7 status"}, int'(status_o), mstat(mlvl));
    chk({tag, " R8 blank"}, int'(blank_req_o), int'(!mlock(mlvl) || mhold != 0));
  endtask

  task automatic run_line(int w, bit dn, int gap, string tag);
    bit old_lock;
    for (int k = 0; k < w; k++) begin
      @(negedge clk); if (dn) err_dn = 1'b1; else err_up = 1'b1;
    end
    @(negedge clk); err_up = 1'b0; err_dn = 1'b0;
    for (int k = 0; k < gap; k++) @(negedge clk);
    line_stb = 1'b1;
    @(negedge clk); line_stb = 1'b0;
    old_lock = mlock(mlvl);
    if (w >= 9) mlvl = mlvl - mdec(mlvl);
    else        mlvl = (mlvl + 16 > 1023) ? 1023 : mlvl + 16;
    if (!old_lock)      mhold = int'(blank_lines);
    else if (mhold > 0) mhold--;
    if (!mlock(mlvl))   mhold = int'(blank_lines);
    chk_all(tag);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", int'(status_o), 0);
    chk("R1 lock", int'(lock_o), 0);
    chk("R1 blank", int'(blank_req_o), 1);

    // R3 climb with narrow pulses on both error lines and empty lines; R8 with 3 extra lines
    for (int i = 0; i < 70; i++)
      run_line((i % 5 == 0) ? 0 : (i % 8) + 1, bit'(i % 2), 3, "R3 climb");

    // R2 width sweep from saturation
    for (int w = 0; w <= 14; w++) begin
      while (mlvl < 1023) run_line(2, 1'b0, 2, "R3 restore");
      run_line(w, bit'(w % 2), 4, "R2 sweep");
    end

    // R4 wide-line decay down through every grade and to zero
    for (int i = 0; i < 90; i++)
      run_line(9 + (i % 6), bit'(i % 3 == 0), 2, "R4 decay");
    chk("R4 floor", int'(status_o), 0);

    // R8 with zero extra lines
    blank_lines = 8'd0;
    for (int i = 0; i < 66; i++) run_line(1, 1'b0, 2, "R8 zero");

    // R5 timeout decay
    for (int k = 0; k < 22; k++) begin
      int n;
      n = (k == 0) ? 1024 + 512 : 1024;
      if (k == 0) begin
        repeat (n) @(negedge clk);
      end else begin
        repeat (n) @(negedge clk);
      end
      mlvl = mlvl - mdec(mlvl);
      if (!mlock(mlvl)) mhold = int'(blank_lines);
      chk_all("R5 idle");
    end
    finish_up();
  end
endmodule